// File: doc/BRIEF.md
# Page-Mode DRAM Controller with EDO Bus Release

This block sits between a 32-bit processor bus and one bank of page-mode DRAM. It accepts single-word reads, single-word writes and four-word cache-line burst reads. It drives the multiplexed row/column address and the active-low row strobe, column strobe and write strobe, and it raises a one-clock ready for every word it moves. Data pins are not part of this block. It only sequences the strobes that make the memory drive or sample the bus.

Two memory types can be selected for each request. With conventional fast-page memory, raising the column strobe makes the memory stop driving the data bus. With extended-data-out memory, the output stays driven after the column strobe rises. After every such read the controller therefore adds one clock in which only the write strobe is low. This forces the memory off the bus but leaves the page open and starts no write. A 2-bit speed setting selects one of four timing presets. The row stays open between accesses, and a request to a different row first precharges and then opens the new row.

Top module: `dram_pm_ctrl`

## Requirements
- R1: After reset, `ras_n`, `cas_n` and `we_n` are high, `rdy` is low and `bus_free` is high. No row counts as open, so the first access after reset is handled as a row miss.
- R2: `speed` and `edo_mode` are sampled when a request is accepted. The lead-off is L = 3 + speed clocks. The per-word spacing is P = 1 + speed for EDO, and P = max(2, 1 + speed) for FPM. With the cycle of acceptance numbered 0 and a row hit, word k has `rdy` high in cycle L + k·P. `rdy` is high for exactly one clock per word: four words for a burst read and one for a single read or a write.
- R3: `cas_n` is low in exactly the cycles where `rdy` is high. In those cycles `ram_addr` carries the column, which is the low COL_W bits of `req_addr`, zero-extended. For word k of a burst read, the two low column bits are replaced by k.
- R4: A hit on the open row adds no cycles, and `ras_n` stays low throughout. On a miss, everything in R2 shifts by PRE_CLKS + RCD_CLKS. `ras_n` is high for the first PRE_CLKS cycles and then low. During the next RCD_CLKS cycles `ram_addr` carries the row, which is the upper ROW_W bits of `req_addr`.
- R5: A write is always one word, whatever `req_burst` says. `we_n` is low through every cycle of its column window, from the first cycle after any row opening up to and including the cycle with `cas_n` low.
- R6: After an EDO read (single or burst), the cycle after the last `rdy` has `we_n` low, `cas_n` high, `rdy` low and `bus_free` still low. `bus_free` returns high in the cycle after that.
- R7: An FPM read never drives `we_n` low, and `bus_free` goes high in the cycle right after the last `rdy`.
- R8: `we_n` and `cas_n` are never low together except in a write.
- R9: A request is accepted only while `bus_free` is high. `bus_free` is low from the cycle after acceptance to the end of the operation, and requests made in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| edo_mode | input | 1 | 1 = extended-data-out memory, 0 = fast-page memory |
| speed | input | 2 | Timing preset, 0 fastest to 3 slowest |
| req_valid | input | 1 | Request strobe, taken when bus_free is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word line read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| ram_addr | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| rdy | output | 1 | One-clock ready per word |
| bus_free | output | 1 | High when idle and the data bus is released |

## Verification
The hardest case to reach is the release pulse right after a back-to-back EDO burst at the fastest preset. There, `cas_n` is low for four consecutive cycles and the lone `we_n` pulse must follow at once without touching the column strobe. A one-cycle error in where it falls shows up only in that combination. The stimulus sweeps both memory types across all four presets. For each, it runs burst, single-read and write accesses on both hits and misses, with column low bits set so that burst word ordering is visible. Every cycle of every operation is compared against a schedule the bench computes from L, P and the miss penalty.

// File: rtl/dram_pm_pkg.sv
package dram_pm_pkg;

    localparam int TW             = 3;
    localparam int LEAD_MIN       = 3;
    localparam int FPM_PER_MIN    = 2;
    localparam int WORDS_PER_LINE = 4;

    typedef logic [TW-1:0] tclk_t;

    typedef struct packed {
        tclk_t lead;
        tclk_t per;
    } timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_REL
    } state_t;

    function automatic timing_t preset(input logic edo, input logic [1:0] spd);
        timing_t t;
        tclk_t   p;
        t.lead = tclk_t'(LEAD_MIN) + tclk_t'(spd);
        p      = tclk_t'(1) + tclk_t'(spd);
        if (!edo && p < tclk_t'(FPM_PER_MIN))
            p = tclk_t'(FPM_PER_MIN);
        t.per = p;
        return t;
    endfunction

endpackage

// File: rtl/dram_pm_timing.sv
module dram_pm_timing
    import dram_pm_pkg::*;
(
    input  logic       edo,
    input  logic [1:0] spd,
    output timing_t    tim
);
    always_comb tim = preset(edo, spd);
endmodule

// File: rtl/dram_pm_rowtrack.sv
module dram_pm_rowtrack #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] new_row,
    output logic             open_valid,
    output logic             hit
);
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_valid <= 1'b0;
            open_row   <= '0;
        end else if (load) begin
            open_valid <= 1'b1;
            open_row   <= new_row;
        end
    end

    assign hit = open_valid && (open_row == new_row);
endmodule

// File: rtl/dram_pm_seq.sv
module dram_pm_seq
    import dram_pm_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int COL_W    = 10,
    parameter int MA_W     = 10,
    parameter int PRE_CLKS = 2,
    parameter int RCD_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_burst,
    input  logic             edo,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  timing_t          tim,
    input  logic             row_hit,
    input  logic             row_open,
    output logic             accept,
    output logic [MA_W-1:0]  ram_addr,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             rdy,
    output logic             bus_free
);
    localparam int IDX_W   = $clog2(WORDS_PER_LINE);
    localparam int TMAX    = (1 << TW) - 1;
    localparam int MAX_A   = (PRE_CLKS > RCD_CLKS) ? PRE_CLKS : RCD_CLKS;
    localparam int MAX_CNT = (MAX_A > TMAX) ? MAX_A : TMAX;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    state_t           state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             wr_q, burst_q, rel_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    tclk_t            lead_q, per_q;
    logic             last_cnt, last_word;
    logic [COL_W-1:0] col_addr;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign last_cnt  = (cnt_q == CNT_W'(1));
    assign last_word = wr_q || !burst_q || (idx_q == IDX_W'(WORDS_PER_LINE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            burst_q <= 1'b0;
            rel_q   <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            lead_q  <= '0;
            per_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    wr_q    <= req_write;
                    burst_q <= req_burst && !req_write;
                    rel_q   <= edo && !req_write;
                    row_q   <= req_row;
                    col_q   <= req_col;
                    lead_q  <= tim.lead;
                    per_q   <= tim.per;
                    idx_q   <= '0;
                    if (row_hit) begin
                        state_q <= ST_COL;
                        cnt_q   <= CNT_W'(tim.lead);
                    end else begin
                        state_q <= ST_PRE;
                        cnt_q   <= CNT_W'(PRE_CLKS);
                    end
                end
                ST_PRE: begin
                    if (last_cnt) begin
                        state_q <= ST_ROW;
                        cnt_q   <= CNT_W'(RCD_CLKS);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_ROW: begin
                    if (last_cnt) begin
                        state_q <= ST_COL;
                        cnt_q   <= CNT_W'(lead_q);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_COL: begin
                    if (last_cnt) begin
                        if (last_word) begin
                            state_q <= rel_q ? ST_REL : ST_IDLE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                            cnt_q <= CNT_W'(per_q);
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                ST_REL:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        col_addr = col_q;
        if (burst_q)
            col_addr[IDX_W-1:0] = idx_q;
    end

    assign ram_addr = (state_q == ST_COL || state_q == ST_REL) ? MA_W'(col_addr) : MA_W'(row_q);
    assign ras_n    = !row_open || (state_q == ST_PRE);
    assign cas_n    = !((state_q == ST_COL) && last_cnt);
    assign rdy      = (state_q == ST_COL) && last_cnt;
    assign we_n     = !(((state_q == ST_COL) && wr_q) || (state_q == ST_REL));
    assign bus_free = (state_q == ST_IDLE);
endmodule

// File: rtl/dram_pm_ctrl.sv
module dram_pm_ctrl
    import dram_pm_pkg::*;
#(
    parameter int ROW_W    = 10,
    parameter int COL_W    = 10,
    parameter int PRE_CLKS = 2,
    parameter int RCD_CLKS = 2,
    localparam int ADDR_W  = ROW_W + COL_W,
    localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edo_mode,
    input  logic [1:0]        speed,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [MA_W-1:0]   ram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              rdy,
    output logic              bus_free
);
    timing_t          tim;
    logic             accept, row_hit, row_open;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    dram_pm_timing timing_i (
        .edo (edo_mode),
        .spd (speed),
        .tim (tim)
    );

    dram_pm_rowtrack #(.ROW_W(ROW_W)) rows_i (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .new_row    (req_row),
        .open_valid (row_open),
        .hit        (row_hit)
    );

    dram_pm_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W),
        .PRE_CLKS(PRE_CLKS), .RCD_CLKS(RCD_CLKS)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_burst (req_burst),
        .edo       (edo_mode),
        .req_row   (req_row),
        .req_col   (req_col),
        .tim       (tim),
        .row_hit   (row_hit),
        .row_open  (row_open),
        .accept    (accept),
        .ram_addr  (ram_addr),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .rdy       (rdy),
        .bus_free  (bus_free)
    );
endmodule

// File: rtl/dram_pm_chk.sv
module dram_pm_chk (
    input logic clk,
    input logic rst,
    input logic edo_mode,
    input logic req_valid,
    input logic req_write,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic rdy,
    input logic bus_free
);
    logic op_wr, op_edo;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_wr  <= 1'b0;
            op_edo <= 1'b0;
        end else if (req_valid && bus_free) begin
            op_wr  <= req_write;
            op_edo <= edo_mode;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_free && ras_n && cas_n && we_n && !rdy)); // R1
    AST_RDY_WITH_CAS: assert property (@(posedge clk) disable iff (rst)
        rdy |-> !cas_n); // R3
    AST_CAS_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> rdy); // R3
    AST_CAS_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n); // R4
    AST_NO_FALSE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!we_n && !cas_n) |-> op_wr); // R8
    AST_EDO_RELEASE_END: assert property (@(posedge clk) disable iff (rst)
        (!we_n && cas_n && !op_wr && !bus_free) |=> bus_free); // R6
    AST_FPM_NO_WE: assert property (@(posedge clk) disable iff (rst)
        (!op_edo && !op_wr && !bus_free) |-> we_n); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && bus_free) |=> !bus_free); // R9
endmodule

bind dram_pm_ctrl dram_pm_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .edo_mode  (edo_mode),
    .req_valid (req_valid),
    .req_write (req_write),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .rdy       (rdy),
    .bus_free  (bus_free)
);

// File: tb/dram_pm_ctrl_tb.sv
module dram_pm_ctrl_tb_top;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 10;
    localparam int PRE    = 2;
    localparam int RCD    = 2;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int MA_W   = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              edo_mode = 1'b0;
    logic [1:0]        speed = 2'd0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_burst = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [MA_W-1:0]   ram_addr;
    logic              ras_n, cas_n, we_n, rdy, bus_free;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  open_valid_m = 1'b0;
    int  open_row_m   = 0;

    always #10ns clk = ~clk;

    dram_pm_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .PRE_CLKS(PRE), .RCD_CLKS(RCD)) dut_i (
        .clk(clk), .rst(rst), .edo_mode(edo_mode), .speed(speed),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .ram_addr(ram_addr), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .rdy(rdy), .bus_free(bus_free)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_op(input bit edo, input int spd, input bit wr, input bit bst,
                          input int row, input int col);
        bit hit, rel;
        int m, lead, per, nw, total;
        hit  = open_valid_m && (row == open_row_m);
        m    = hit ? 0 : PRE + RCD;
        lead = 3 + spd;
        per  = edo ? (1 + spd) : ((1 + spd) < 2 ? 2 : (1 + spd));
        nw   = (wr || !bst) ? 1 : 4;
        rel  = edo && !wr;
        total = m + lead + (nw - 1) * per + (rel ? 1 : 0);

        check(bus_free == 1'b1, "R9", "bus_free before request", int'(bus_free), 1);
        edo_mode  = edo;
        speed     = 2'(spd);
        req_write = wr;
        req_burst = bst;
        req_addr  = {ROW_W'(row), COL_W'(col)};
        req_valid = 1'b1;
        @(posedge clk);
        open_valid_m = 1'b1;
        open_row_m   = row;
        for (int c = 1; c <= total + 1; c++) begin
            int  d, k, ecol;
            bit  e_rdy, e_we_low, e_ras_n, e_free;
            @(negedge clk);
            // R9: the request stays up in cycle 1 while busy and must be ignored
            if (c == 2) req_valid = 1'b0;
            d        = c - m - lead;
            e_rdy    = (d >= 0) && (d % per == 0) && (d / per < nw);
            k        = (d >= 0) ? d / per : 0;
            e_we_low = (wr && c > m && c <= m + lead) || (rel && c == total);
            e_ras_n  = !hit && c <= PRE;
            e_free   = c > total;
            check(rdy == e_rdy, "R2", "rdy", int'(rdy), int'(e_rdy));
            check(cas_n == !e_rdy, "R3", "cas_n", int'(cas_n), int'(!e_rdy));
            check(ras_n == e_ras_n, "R4", "ras_n", int'(ras_n), int'(e_ras_n));
            if (wr)
                check(we_n == !e_we_low, "R5", "we_n write", int'(we_n), int'(!e_we_low));
            else if (edo)
                check(we_n == !e_we_low, "R6", "we_n edo release", int'(we_n), int'(!e_we_low));
            else
                check(we_n == 1'b1, "R7", "we_n fpm read", int'(we_n), 1);
            check(bus_free == e_free, rel ? "R6" : (wr ? "R9" : "R7"), "bus_free",
                  int'(bus_free), int'(e_free));
            if (e_rdy) begin
                ecol = (bst && !wr) ? ((col & ~3) | (k & 3)) : col;
                check(int'(ram_addr) == ecol, "R3", "column address", int'(ram_addr), ecol);
            end
            if (!hit && c > PRE && c <= m)
                check(int'(ram_addr) == row, "R4", "row address", int'(ram_addr), row);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ras_n && cas_n && we_n, "R1", "strobes after reset",
              int'({ras_n, cas_n, we_n}), 7);
        check(!rdy, "R1", "rdy after reset", int'(rdy), 0);
        check(bus_free, "R1", "bus_free after reset", int'(bus_free), 1);
        for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 4; s++) begin
                int r;
                r = e * 16 + s * 4 + 1;
                run_op(bit'(e), s, 1'b0, 1'b1, r,     'h05A);
                run_op(bit'(e), s, 1'b0, 1'b1, r,     'h123);
                run_op(bit'(e), s, 1'b0, 1'b0, r,     'h3FF);
                run_op(bit'(e), s, 1'b1, 1'b1, r,     'h040);
                run_op(bit'(e), s, 1'b0, 1'b0, r + 1, 'h001);
                run_op(bit'(e), s, 1'b1, 1'b0, r + 2, 'h2AA);
                run_op(bit'(e), s, 1'b0, 1'b1, r + 2, 'h2A7);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule